// File: doc/BRIEF.md
# Alarm and Watchdog Interrupt Controller

This block merges three event sources into one interrupt pin. The first source is a time-of-day alarm. It compares four programmed fields (second, minute, hour, day) with the running clock. The second is a countdown watchdog that the host must keep restarting. The third is a power-fail input. Each event sets a sticky flag in a flags register. Reading that register returns the flags and clears them. A control register holds one enable per source, the pin polarity and drive type, and the choice between a level output and a fixed-width pulse.

The host reaches the block through a simple register port with eight 8-bit registers:

| Select | Register | Fields |
|---|---|---|
| 0 | control | bit0 alarm enable, bit1 watchdog enable, bit2 power-fail enable, bit3 push-pull active-high (0 = open-drain active-low), bit4 pulse mode (0 = level) |
| 1 | watchdog | bits[6:0] load value, bit7 restart strobe |
| 2 | flags | bit0 alarm, bit1 watchdog, bit2 power-fail; read-to-clear, writes ignored |
| 3 | alarm second | bits[5:0] |
| 4 | alarm minute | bits[5:0] |
| 5 | alarm hour | bits[5:0] |
| 6 | alarm day | bits[5:0] |
| 7 | alarm mode | bits[2:0] |

A write takes effect at the clock edge that samples it. A read returns its data at the edge after `rd_en` is sampled.

The clock counter lies outside the block. It supplies the current fields together with a one-cycle `tick_sec` at each new second. A separate one-cycle `tick_wd` paces the watchdog.

Top module: `event_irq_hub`

## Requirements
- R1: After reset all registers and flags read 0, and the pin is inactive: `irq_oe` = 0 and `irq_o` = 1.
- R2: The alarm is evaluated only in a cycle with `tick_sec` high. Mode 1 compares seconds. Mode 2 compares seconds and minutes. Mode 3 compares seconds, minutes and hours. Mode 4 compares all four fields and repeats on every match. A match sets flag bit0.
- R3: Mode 0 compares all four fields and fires once. A later match sets no flag until the alarm mode register is written again.
- R4: After a write with bit7 = 1 and load N > 0, and one idle cycle, the Nth `tick_wd` sets flag bit1. Earlier ticks set nothing. A new strobe restarts the full count of N.
- R5: A load value of 0 disables the watchdog: no number of ticks sets flag bit1.
- R6: The strobe bit reads back 1 in the cycle right after the write. After the reload it reads 0.
- R7: A rising edge on `pfail_in` sets flag bit2. A level that stays high sets nothing more.
- R8: Flags latch whether or not their source is enabled. A flags read returns the flags and clears them. An event in the same cycle as the read survives the clear.
- R9: In level mode the pin is asserted while any flag whose enable bit is set is 1.
- R10: In pulse mode each enabled event asserts the pin for exactly PULSE_W cycles, even while the flag stays set.
- R11: With control bit3 = 1 the pin drives `irq_oe` = 1 and `irq_o` = asserted. With bit3 = 0 `irq_oe` = asserted, and `irq_o` = 0 whenever `irq_oe` = 1.
- R12: A source whose enable bit is 0 never asserts the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| tick_sec | input | 1 | One-cycle pulse at each new second |
| tick_wd | input | 1 | Watchdog time base pulse |
| cur_sec | input | FIELD_W | Current second |
| cur_min | input | FIELD_W | Current minute |
| cur_hour | input | FIELD_W | Current hour |
| cur_day | input | FIELD_W | Current day |
| pfail_in | input | 1 | Power-fail indication |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
The bench walks the alarm through every mode. In each mode it first gives a tick where only the next, still-ignored field is wrong, so a wrong field mask either misses a match or fires early. It checks that one-shot mode stays silent after its first match until rearmed. It also checks that a flags read landing on the same edge as a new alarm still leaves the flag set; a design that let the clear win would lose that event. The watchdog is counted tick by tick both from a fresh strobe and after a mid-count restart, so an off-by-one expiry shows up. A load of zero must stay silent over many ticks, and the strobe bit must be seen set and then self-cleared. In pulse mode it counts the asserted cycles while the flag is still set, which exposes a pulse of the wrong width or a fall back to level behaviour.

// File: rtl/hub_pkg.sv
package hub_pkg;
    // register selects
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_WDOG  = 3'd1;
    localparam logic [2:0] SEL_FLAGS = 3'd2;
    localparam logic [2:0] SEL_ASEC  = 3'd3;
    localparam logic [2:0] SEL_AMIN  = 3'd4;
    localparam logic [2:0] SEL_AHOUR = 3'd5;
    localparam logic [2:0] SEL_ADAY  = 3'd6;
    localparam logic [2:0] SEL_AMODE = 3'd7;

    // source indices in the flag and enable vectors
    localparam int SRC_ALM = 0;
    localparam int SRC_WDT = 1;
    localparam int SRC_PWR = 2;
    localparam int NSRC    = 3;

    // control register bit positions
    localparam int CB_PP    = 3;
    localparam int CB_PULSE = 4;
    localparam int CTRL_W   = 5;

    typedef enum logic [2:0] {
        AM_ONCE = 3'd0,
        AM_SEC  = 3'd1,
        AM_MIN  = 3'd2,
        AM_HOUR = 3'd3,
        AM_DAY  = 3'd4
    } alm_mode_e;
endpackage

// File: rtl/irq_alarm_match.sv
module irq_alarm_match
    import hub_pkg::*;
#(
    parameter int FIELD_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_day,
    input  logic [FIELD_W-1:0] set_sec,
    input  logic [FIELD_W-1:0] set_min,
    input  logic [FIELD_W-1:0] set_hour,
    input  logic [FIELD_W-1:0] set_day,
    input  logic [2:0]         mode,
    input  logic               rearm,
    output logic               hit
);
    localparam int NFIELD = 4;

    typedef struct packed {
        logic armed;
    } alm_state_t;

    alm_state_t st_d, st_q;
    logic [NFIELD-1:0] eq;
    logic [NFIELD-1:0] mask;
    logic              mode_ok;

    logic [FIELD_W-1:0] cur_f [NFIELD];
    logic [FIELD_W-1:0] set_f [NFIELD];

    assign cur_f[0] = cur_sec;
    assign cur_f[1] = cur_min;
    assign cur_f[2] = cur_hour;
    assign cur_f[3] = cur_day;
    assign set_f[0] = set_sec;
    assign set_f[1] = set_min;
    assign set_f[2] = set_hour;
    assign set_f[3] = set_day;

    for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
        assign eq[g] = (cur_f[g] == set_f[g]);
    end

    always_comb begin
        mode_ok = 1'b1;
        case (mode)
            AM_SEC:  mask = 4'b0001;
            AM_MIN:  mask = 4'b0011;
            AM_HOUR: mask = 4'b0111;
            AM_DAY:  mask = 4'b1111;
            AM_ONCE: mask = 4'b1111;
            default: begin
                mask    = 4'b0000;
                mode_ok = 1'b0;
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        hit  = tick && st_q.armed && mode_ok && (&(eq | ~mask));
        if (hit && (mode == AM_ONCE)) begin
            st_d.armed = 1'b0;
        end
        if (rearm) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_wdog_timer.sv
module irq_wdog_timer #(
    parameter int WD_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [WD_W-1:0] load,
    input  logic            reload,
    output logic            expire
);
    typedef struct packed {
        logic [WD_W-1:0] cnt;
    } wd_state_t;

    wd_state_t st_d, st_q;
    logic      running;

    assign running = (load != '0);

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (reload) begin
            st_d.cnt = load;
        end else if (tick && running) begin
            if (st_q.cnt <= WD_W'(1)) begin
                expire   = 1'b1;
                st_d.cnt = load;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_out_shaper.sv
module irq_out_shaper #(
    parameter int NS      = 3,
    parameter int PULSE_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] flags,
    input  logic [NS-1:0] events,
    input  logic [NS-1:0] enables,
    input  logic          pulse_mode,
    input  logic          push_pull,
    output logic          irq_o,
    output logic          irq_oe
);
    localparam int CW = $clog2(PULSE_W + 1);

    typedef struct packed {
        logic [CW-1:0] pcnt;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic      active;
    logic      new_evt;

    assign new_evt = |(events & enables);

    always_comb begin
        st_d = st_q;
        if (new_evt) begin
            st_d.pcnt = CW'(PULSE_W);
        end else if (st_q.pcnt != '0) begin
            st_d.pcnt = st_q.pcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = pulse_mode ? (st_q.pcnt != '0) : (|(flags & enables));

    always_comb begin
        if (push_pull) begin
            irq_o  = active;
            irq_oe = 1'b1;
        end else begin
            irq_o  = ~active;
            irq_oe = active;
        end
    end
endmodule

// File: rtl/event_irq_hub.sv
module event_irq_hub
    import hub_pkg::*;
#(
    parameter int FIELD_W = 6,
    parameter int WD_W    = 7,
    parameter int PULSE_W = 4,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [2:0]         rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               tick_sec,
    input  logic               tick_wd,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_day,
    input  logic               pfail_in,
    output logic               irq_o,
    output logic               irq_oe
);
    localparam int MODE_W = 3;

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [WD_W-1:0]    wd_load;
        logic               wd_strobe;
        logic [NSRC-1:0]    flags;
        logic [FIELD_W-1:0] a_sec;
        logic [FIELD_W-1:0] a_min;
        logic [FIELD_W-1:0] a_hour;
        logic [FIELD_W-1:0] a_day;
        logic [MODE_W-1:0]  a_mode;
        logic               pf_q;
        logic [DATA_W-1:0]  rd_data;
    } hub_regs_t;

    hub_regs_t r_d, r_q;

    logic            alm_hit;
    logic            wd_expire;
    logic            pf_rise;
    logic            flag_rd;
    logic [NSRC-1:0] evt_vec;
    logic [NSRC-1:0] ie_vec;
    logic            ctl_pp;
    logic            ctl_pulse;
    logic            strobe_q;
    logic [NSRC-1:0] flags_q;
    logic [WD_W-1:0] wd_load_q;

    assign pf_rise   = pfail_in && !r_q.pf_q;
    assign flag_rd   = rd_en && (rd_sel == SEL_FLAGS);
    assign ie_vec    = r_q.ctrl[NSRC-1:0];
    assign ctl_pp    = r_q.ctrl[CB_PP];
    assign ctl_pulse = r_q.ctrl[CB_PULSE];
    assign strobe_q  = r_q.wd_strobe;
    assign flags_q   = r_q.flags;
    assign wd_load_q = r_q.wd_load;

    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_ALM] = alm_hit;
        evt_vec[SRC_WDT] = wd_expire;
        evt_vec[SRC_PWR] = pf_rise;
    end

    irq_alarm_match #(.FIELD_W(FIELD_W)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_sec),
        .cur_sec  (cur_sec),
        .cur_min  (cur_min),
        .cur_hour (cur_hour),
        .cur_day  (cur_day),
        .set_sec  (r_q.a_sec),
        .set_min  (r_q.a_min),
        .set_hour (r_q.a_hour),
        .set_day  (r_q.a_day),
        .mode     (r_q.a_mode),
        .rearm    (wr_en && (wr_sel == SEL_AMODE)),
        .hit      (alm_hit)
    );

    irq_wdog_timer #(.WD_W(WD_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_wd),
        .load   (r_q.wd_load),
        .reload (r_q.wd_strobe),
        .expire (wd_expire)
    );

    irq_out_shaper #(.NS(NSRC), .PULSE_W(PULSE_W)) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (r_q.flags),
        .events     (evt_vec),
        .enables    (ie_vec),
        .pulse_mode (ctl_pulse),
        .push_pull  (ctl_pp),
        .irq_o      (irq_o),
        .irq_oe     (irq_oe)
    );

    always_comb begin
        r_d           = r_q;
        r_d.pf_q      = pfail_in;
        r_d.wd_strobe = 1'b0;

        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL:  r_d.ctrl = wr_data[CTRL_W-1:0];
                SEL_WDOG: begin
                    r_d.wd_load   = wr_data[WD_W-1:0];
                    r_d.wd_strobe = wr_data[DATA_W-1];
                end
                SEL_ASEC:  r_d.a_sec  = wr_data[FIELD_W-1:0];
                SEL_AMIN:  r_d.a_min  = wr_data[FIELD_W-1:0];
                SEL_AHOUR: r_d.a_hour = wr_data[FIELD_W-1:0];
                SEL_ADAY:  r_d.a_day  = wr_data[FIELD_W-1:0];
                SEL_AMODE: r_d.a_mode = wr_data[MODE_W-1:0];
                default: ;
            endcase
        end

        r_d.flags = (flag_rd ? '0 : r_q.flags) | evt_vec;

        if (rd_en) begin
            r_d.rd_data = '0;
            case (rd_sel)
                SEL_CTRL:  r_d.rd_data[CTRL_W-1:0] = r_q.ctrl;
                SEL_WDOG: begin
                    r_d.rd_data[WD_W-1:0]   = r_q.wd_load;
                    r_d.rd_data[DATA_W-1]   = r_q.wd_strobe;
                end
                SEL_FLAGS: r_d.rd_data[NSRC-1:0]    = r_q.flags;
                SEL_ASEC:  r_d.rd_data[FIELD_W-1:0] = r_q.a_sec;
                SEL_AMIN:  r_d.rd_data[FIELD_W-1:0] = r_q.a_min;
                SEL_AHOUR: r_d.rd_data[FIELD_W-1:0] = r_q.a_hour;
                SEL_ADAY:  r_d.rd_data[FIELD_W-1:0] = r_q.a_day;
                default:   r_d.rd_data[MODE_W-1:0]  = r_q.a_mode;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.rd_data;
endmodule

// File: rtl/event_irq_hub_chk.sv
module event_irq_hub_chk
    import hub_pkg::*;
#(
    parameter int NS = 3,
    parameter int WW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_sel,
    input logic          wr_top,
    input logic          rd_en,
    input logic [2:0]    rd_sel,
    input logic          irq_o,
    input logic          irq_oe,
    input logic          pp,
    input logic          pulse,
    input logic [NS-1:0] ie,
    input logic          strobe,
    input logic [NS-1:0] flags,
    input logic [NS-1:0] evt,
    input logic [WW-1:0] wd_load
);
    logic asserted;
    logic flags_read;
    logic strobe_wr;

    assign asserted   = pp ? irq_o : irq_oe;
    assign flags_read = rd_en && (rd_sel == SEL_FLAGS);
    assign strobe_wr  = wr_en && (wr_sel == SEL_WDOG) && wr_top;

    assert_od_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pp && irq_oe) |-> !irq_o);

    assert_pp_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pp |-> irq_oe);

    assert_strobe_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !strobe_wr) |=> !strobe);

    assert_zero_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_load == '0) |-> !evt[SRC_WDT]);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_read |=> (flags == $past(evt)));

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_read |=> ((flags & $past(flags)) == $past(flags)));

    assert_level_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && ((flags & ie) != '0)) |-> asserted);

    assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && ((flags & ie) == '0)) |-> !asserted);
endmodule

bind event_irq_hub event_irq_hub_chk #(.NS(hub_pkg::NSRC), .WW(WD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_top  (wr_data[DATA_W-1]),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .irq_o   (irq_o),
    .irq_oe  (irq_oe),
    .pp      (ctl_pp),
    .pulse   (ctl_pulse),
    .ie      (ie_vec),
    .strobe  (strobe_q),
    .flags   (flags_q),
    .evt     (evt_vec),
    .wd_load (wd_load_q)
);

// File: tb/test_event_irq_hub.sv
module test_event_irq_hub;
    localparam int FW = 6;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [2:0]    rd_sel = '0;
    logic [7:0]    rd_data;
    logic          tick_sec = 1'b0;
    logic          tick_wd = 1'b0;
    logic [FW-1:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0;
    logic          pfail_in = 1'b0;
    logic          irq_o, irq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    logic      rd_seen = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    event_irq_hub #(.FIELD_W(FW), .PULSE_W(PW)) i_event_irq_hub (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .tick_sec(tick_sec), .tick_wd(tick_wd),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .pfail_in(pfail_in), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    // monitor: compares read data against the scoreboard queue
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            exp_item_t it;
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL %s: read with empty scoreboard, got %02h", "SB", rd_data);
            end else begin
                it = sb_q.pop_front();
                if (rd_data !== it.exp) begin
                    fails++;
                    $display("FAIL %s: rd_data got %02h expected %02h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input logic [7:0] e, input string tag);
        sb_q.push_back('{exp: e, tag: tag});
        rd_en = 1'b1; rd_sel = s;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tsec();
        tick_sec = 1'b1;
        @(negedge clk);
        tick_sec = 1'b0;
    endtask

    task automatic twd();
        tick_wd = 1'b1;
        @(negedge clk);
        tick_wd = 1'b0;
    endtask

    task automatic chk_pin(input string tag, input logic got_o, input logic got_oe,
                           input logic exp_o, input logic exp_oe);
        checks++;
        if (got_o !== exp_o || got_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s: irq_o/irq_oe got %b/%b expected %b/%b",
                     tag, got_o, got_oe, exp_o, exp_oe);
        end
    endtask

    task automatic set_time(input int s, input int m, input int h, input int d);
        cur_sec = FW'(s); cur_min = FW'(m); cur_hour = FW'(h); cur_day = FW'(d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL WATCHDOG: run hung, got running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_pin("R1", irq_o, irq_oe, 1'b1, 1'b0);
        rd(3'd2, 8'h00, "R1");
        rd(3'd0, 8'h00, "R1");
        rd(3'd1, 8'h00, "R1");

        // alarm setup: 10 s, 20 min, 3 h, day 5; push-pull level, alarm enabled
        wr(3'd0, 8'h09);
        wr(3'd3, 8'd10); wr(3'd4, 8'd20); wr(3'd5, 8'd3); wr(3'd6, 8'd5);
        rd(3'd5, 8'd3, "R2");
        set_time(10, 0, 0, 1);
        wr(3'd7, 8'd1);
        @(negedge clk);
        rd(3'd2, 8'h00, "R2");                 // match but no tick
        chk_pin("R9", irq_o, irq_oe, 1'b0, 1'b1);
        tsec();
        chk_pin("R9", irq_o, irq_oe, 1'b1, 1'b1);
        rd(3'd2, 8'h01, "R2");
        chk_pin("R8", irq_o, irq_oe, 1'b0, 1'b1);
        set_time(9, 0, 0, 1);
        tsec();
        rd(3'd2, 8'h00, "R2");

        // mode 2: seconds and minutes
        wr(3'd7, 8'd2);
        set_time(10, 0, 0, 1); tsec(); rd(3'd2, 8'h00, "R2");
        set_time(10, 20, 0, 1); tsec(); rd(3'd2, 8'h01, "R2");
        // mode 3: plus hours
        wr(3'd7, 8'd3);
        tsec(); rd(3'd2, 8'h00, "R2");
        set_time(10, 20, 3, 1); tsec(); rd(3'd2, 8'h01, "R2");
        // mode 4: all fields, repeating
        wr(3'd7, 8'd4);
        tsec(); rd(3'd2, 8'h00, "R2");
        set_time(10, 20, 3, 5); tsec(); rd(3'd2, 8'h01, "R2");
        tsec(); rd(3'd2, 8'h01, "R2");

        // R8: event in the same cycle as a flags read survives
        sb_q.push_back('{exp: 8'h00, tag: "R8"});
        tick_sec = 1'b1; rd_en = 1'b1; rd_sel = 3'd2;
        @(negedge clk);
        tick_sec = 1'b0; rd_en = 1'b0;
        rd(3'd2, 8'h01, "R8");

        // R3: one-shot
        wr(3'd7, 8'd0);
        tsec(); rd(3'd2, 8'h01, "R3");
        tsec(); rd(3'd2, 8'h00, "R3");
        wr(3'd7, 8'd0);
        tsec(); rd(3'd2, 8'h01, "R3");

        // R12 / R8: disabled source latches its flag but keeps the pin quiet
        wr(3'd7, 8'd4);
        wr(3'd0, 8'h08);
        tsec();
        chk_pin("R12", irq_o, irq_oe, 1'b0, 1'b1);
        rd(3'd2, 8'h01, "R8");

        // R7: power-fail rising edge
        wr(3'd0, 8'h0C);
        pfail_in = 1'b1;
        @(negedge clk);
        chk_pin("R7", irq_o, irq_oe, 1'b1, 1'b1);
        rd(3'd2, 8'h04, "R7");
        @(negedge clk);
        rd(3'd2, 8'h00, "R7");

        // R11: open-drain level
        wr(3'd0, 8'h01);
        chk_pin("R11", irq_o, irq_oe, 1'b1, 1'b0);
        tsec();
        chk_pin("R11", irq_o, irq_oe, 1'b0, 1'b1);
        rd(3'd2, 8'h01, "R11");
        chk_pin("R11", irq_o, irq_oe, 1'b1, 1'b0);

        // R10: pulse mode, open-drain; the flag stays set throughout
        wr(3'd0, 8'h11);
        tsec();
        chk_pin("R10", irq_o, irq_oe, 1'b0, 1'b1);
        for (int i = 1; i < PW; i++) begin
            @(negedge clk);
            chk_pin("R10", irq_o, irq_oe, 1'b0, 1'b1);
        end
        @(negedge clk);
        chk_pin("R10", irq_o, irq_oe, 1'b1, 1'b0);
        rd(3'd2, 8'h01, "R10");

        // watchdog: push-pull level, watchdog enabled, alarm mode parked
        wr(3'd7, 8'd5);
        wr(3'd0, 8'h0A);
        wr(3'd1, 8'h85);
        rd(3'd1, 8'h85, "R6");
        rd(3'd1, 8'h05, "R6");
        for (int i = 0; i < 4; i++) twd();
        rd(3'd2, 8'h00, "R4");
        chk_pin("R4", irq_o, irq_oe, 1'b0, 1'b1);
        twd();
        chk_pin("R4", irq_o, irq_oe, 1'b1, 1'b1);
        rd(3'd2, 8'h02, "R4");

        // R4: restart mid-count
        wr(3'd1, 8'h83);
        rd(3'd1, 8'h83, "R6");
        twd(); twd();
        wr(3'd1, 8'h83);
        rd(3'd1, 8'h83, "R4");
        twd(); twd();
        rd(3'd2, 8'h00, "R4");
        twd();
        rd(3'd2, 8'h02, "R4");

        // R5: zero load disables
        wr(3'd1, 8'h80);
        rd(3'd1, 8'h80, "R6");
        for (int i = 0; i < 20; i++) twd();
        rd(3'd2, 8'h00, "R5");
        chk_pin("R5", irq_o, irq_oe, 1'b0, 1'b1);

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL SB: %0d reads outstanding, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule